// File: doc/BRIEF.md
# MMU and Exception Register Bank

This block is the register file that a small CPU core uses to control its address translation and to record its exceptions. It holds the MMU control word, the high, low and assist halves of a page-table entry, the translation table base, the faulting address, the trap code, and the exception and interrupt event codes. It also holds a refresh counter that advances each time it is read, and three read-only identification words.

Each register is 32 bits wide and is reached only by a 4-byte access at a word-aligned offset. A write stores the value through a mask specific to that register. Two writes also produce a one-cycle pulse on an output. Setting the invalidate bit of the control word raises `tlb_inv_pulse`. Changing the address-space identifier in the page-table-entry-high register raises `tlb_flush_pulse`. The translation buffer that consumes these pulses lives outside the block.

Offsets, in bytes:

| Offset | Register |
|---|---|
| 0x00 | MMU control |
| 0x04 | page-table entry high |
| 0x08 | page-table entry low |
| 0x0C | table base |
| 0x10 | fault address |
| 0x14 | trap code |
| 0x18 | exception event |
| 0x1C | interrupt event |
| 0x20 | page-table assist |
| 0x24 | refresh counter |
| 0x30 | CPU version |
| 0x34 | cache version |
| 0x38 | revision |

Any other offset is unmapped.

Every access is a single-cycle request. Its read data and error flag are registered, so they appear in the cycle after the request.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: After reset, every writable register and the refresh counter read 0, and both pulse outputs and `rsp_err` are low.
- R2: A valid write to offset 0x00 with bit 2 of the data set drives `tlb_inv_pulse` high for exactly the cycle after the write. The control register stores the data with bit 2 forced to 0, so bit 2 always reads back 0. A write with bit 2 clear produces no pulse.
- R3: A valid write to offset 0x04 whose bits [7:0] differ from the stored bits [7:0] drives `tlb_flush_pulse` high for exactly the cycle after the write. When bits [7:0] are equal, including a write of an identical value, no pulse occurs. In both cases the full 32-bit value is stored.
- R4: The page-table assist register (0x20) keeps only bits [3:0] of a write, and reads 0 in bits [31:4].
- R5: The trap code (0x14), exception event (0x18) and interrupt event (0x1C) registers keep only bits [10:0] of a write.
- R6: The page-table entry low (0x08), table base (0x0C) and fault address (0x10) registers store all 32 bits of a write.
- R7: A read of the refresh counter (0x24) returns its current value and then increments the counter by one. A write loads the counter from bits [15:0] of the data.
- R8: A request whose `req_size` is not 4 sets `rsp_err` in the next cycle. Such a request changes no register and raises no pulse, and when it is a read it returns 0.
- R9: A request to an unmapped or non-word-aligned offset sets `rsp_err` in the next cycle, and when it is a read it returns 0.
- R10: The CPU version (0x30), cache version (0x34) and revision (0x38) words read as their parameter values. A write to any of them sets `rsp_err` and leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after a read |
| rsp_err | output | 1 | Error flag, one cycle after a bad request |
| tlb_inv_pulse | output | 1 | One-cycle full invalidate request |
| tlb_flush_pulse | output | 1 | One-cycle flush request on an identifier change |

## Verification
The hardest behaviour to reach is the flush pulse's equality case. The pulse depends on the stored identifier as well as on the new data. Showing that it stays quiet needs a sequence of writes: first one that keeps an identifier of 0 while changing the upper bits, then one that changes the identifier, then one that changes only the upper bits again.

The refresh counter poses a second problem: reading it changes it, so every read the bench makes must be counted in its expected value. The bench checks that a wrong-size read of the counter does not advance it, by reading the counter correctly just afterwards.

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs #(
  parameter int          ADDR_W    = 8,
  parameter int          ASID_W    = 8,
  parameter int          INV_BIT   = 2,
  parameter int          ASSIST_W  = 4,
  parameter int          EVT_W     = 11,
  parameter int          RFC_W     = 16,
  parameter logic [31:0] CPU_VER   = 32'h0402_0500,
  parameter logic [31:0] CACHE_VER = 32'h2910_0000,
  parameter logic [31:0] REV_ID    = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              tlb_inv_pulse,
  output logic              tlb_flush_pulse
);
  localparam logic [31:0] ASSIST_MASK = (32'h1 << ASSIST_W) - 32'h1;
  localparam logic [31:0] EVT_MASK    = (32'h1 << EVT_W) - 32'h1;
  localparam logic [31:0] CTRL_MASK   = ~(32'h1 << INV_BIT);

  logic [31:0] ctrl_q, pthi_q, ptlo_q, tbase_q, fault_q, trap_q, exc_q, int_q, assist_q;
  logic [RFC_W-1:0] rfc_q;

  logic [ADDR_W-1:0] ofs;
  logic size_ok, mapped, ro, acc_ok, wr_ok, rd_ok, err_c;
  logic [31:0] rd_val;

  assign ofs     = req_addr;
  assign size_ok = (req_size == 3'd4);

  always_comb begin
    mapped = 1'b1;
    ro     = 1'b0;
    rd_val = '0;
    case (ofs)
      ADDR_W'('h00): rd_val = ctrl_q;
      ADDR_W'('h04): rd_val = pthi_q;
      ADDR_W'('h08): rd_val = ptlo_q;
      ADDR_W'('h0C): rd_val = tbase_q;
      ADDR_W'('h10): rd_val = fault_q;
      ADDR_W'('h14): rd_val = trap_q;
      ADDR_W'('h18): rd_val = exc_q;
      ADDR_W'('h1C): rd_val = int_q;
      ADDR_W'('h20): rd_val = assist_q;
      ADDR_W'('h24): rd_val = 32'(rfc_q);
      ADDR_W'('h30): begin rd_val = CPU_VER;   ro = 1'b1; end
      ADDR_W'('h34): begin rd_val = CACHE_VER; ro = 1'b1; end
      ADDR_W'('h38): begin rd_val = REV_ID;    ro = 1'b1; end
      default:       mapped = 1'b0;
    endcase
  end

  assign acc_ok = req_valid && size_ok && mapped;
  assign wr_ok  = acc_ok && req_write && !ro;
  assign rd_ok  = acc_ok && !req_write;
  assign err_c  = req_valid && !(size_ok && mapped && !(req_write && ro));

  logic wr_ctrl, wr_pthi, rd_rfc;
  assign wr_ctrl = wr_ok && (ofs == ADDR_W'('h00));
  assign wr_pthi = wr_ok && (ofs == ADDR_W'('h04));
  assign rd_rfc  = rd_ok && (ofs == ADDR_W'('h24));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; pthi_q <= '0; ptlo_q <= '0; tbase_q <= '0; fault_q <= '0;
      trap_q <= '0; exc_q <= '0; int_q <= '0; assist_q <= '0; rfc_q <= '0;
      rsp_rdata <= '0; rsp_err <= 1'b0;
      tlb_inv_pulse <= 1'b0; tlb_flush_pulse <= 1'b0;
    end else begin
      rsp_err         <= err_c;
      tlb_inv_pulse   <= wr_ctrl && req_wdata[INV_BIT];
      tlb_flush_pulse <= wr_pthi && (req_wdata[ASID_W-1:0] != pthi_q[ASID_W-1:0]);
      if (req_valid && !req_write) rsp_rdata <= rd_ok ? rd_val : 32'h0;
      if (rd_rfc) rfc_q <= rfc_q + 1'b1;
      if (wr_ok) begin
        case (ofs)
          ADDR_W'('h00): ctrl_q   <= req_wdata & CTRL_MASK;
          ADDR_W'('h04): pthi_q   <= req_wdata;
          ADDR_W'('h08): ptlo_q   <= req_wdata;
          ADDR_W'('h0C): tbase_q  <= req_wdata;
          ADDR_W'('h10): fault_q  <= req_wdata;
          ADDR_W'('h14): trap_q   <= req_wdata & EVT_MASK;
          ADDR_W'('h18): exc_q    <= req_wdata & EVT_MASK;
          ADDR_W'('h1C): int_q    <= req_wdata & EVT_MASK;
          ADDR_W'('h20): assist_q <= req_wdata & ASSIST_MASK;
          ADDR_W'('h24): rfc_q    <= req_wdata[RFC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  AST_INV_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_inv_pulse |-> $past(wr_ctrl && req_wdata[INV_BIT])); // R2
  AST_INV_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[INV_BIT] == 1'b0); // R2
  AST_FLUSH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_pulse |-> ($past(wr_pthi) && ($past(pthi_q[ASID_W-1:0]) != $past(req_wdata[ASID_W-1:0])))); // R3
  AST_ASSIST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (assist_q & ~ASSIST_MASK) == 32'h0); // R4
  AST_EVT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ((trap_q | exc_q | int_q) & ~EVT_MASK) == 32'h0); // R5
  AST_RFC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_rfc) |-> (rfc_q == $past(rfc_q) + 1'b1)); // R7
  AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> ($stable(ptlo_q) && $stable(ctrl_q) && !tlb_inv_pulse && !tlb_flush_pulse)); // R8
endmodule

// File: tb/sim_mmu_ctrl_regs.sv
module sim_mmu_ctrl_regs;
  localparam logic [31:0] CPUV = 32'h0402_0500;
  localparam logic [31:0] CACV = 32'h2910_0000;
  localparam logic [31:0] REVV = 32'h0000_0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [2:0] req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic rsp_err, tlb_inv_pulse, tlb_flush_pulse;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mmu_ctrl_regs #(.CPU_VER(CPUV), .CACHE_VER(CACV), .REV_ID(REVV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .tlb_inv_pulse(tlb_inv_pulse), .tlb_flush_pulse(tlb_flush_pulse));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  logic inv_s, flush_s;

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] sz, output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_size = 3'd4;
    err = rsp_err; inv_s = tlb_inv_pulse; flush_s = tlb_flush_pulse;
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] sz, output logic [31:0] d, output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_size = 3'd4;
    d = rsp_rdata; err = rsp_err;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    chk("R1 inv pulse", 32'(tlb_inv_pulse), 0);
    chk("R1 flush pulse", 32'(tlb_flush_pulse), 0);
    chk("R1 err", 32'(rsp_err), 0);
    for (int a = 0; a <= 'h20; a += 4) begin
      rd(8'(a), 3'd4, d, e);
      chk("R1 reg zero", d, 0);
    end
    rd(8'h24, 3'd4, d, e);
    chk("R1 refresh zero", d, 0);
  endtask

  task automatic t_invalidate();
    logic [31:0] d; logic e;
    wr(8'h00, 32'hFFFF_FFFF, 3'd4, e);
    chk("R2 inv pulse high", 32'(inv_s), 1);
    @(negedge clk);
    chk("R2 inv pulse one cycle", 32'(tlb_inv_pulse), 0);
    rd(8'h00, 3'd4, d, e);
    chk("R2 bit2 cleared", d, 32'hFFFF_FFFB);
    wr(8'h00, 32'h0000_0001, 3'd4, e);
    chk("R2 no pulse bit2 clear", 32'(inv_s), 0);
  endtask

  task automatic t_flush();
    logic [31:0] d; logic e;
    wr(8'h04, 32'h1234_5600, 3'd4, e);
    chk("R3 same asid no flush", 32'(flush_s), 0);
    wr(8'h04, 32'h0000_0042, 3'd4, e);
    chk("R3 asid change flush", 32'(flush_s), 1);
    @(negedge clk);
    chk("R3 flush one cycle", 32'(tlb_flush_pulse), 0);
    wr(8'h04, 32'hABCD_0042, 3'd4, e);
    chk("R3 upper only no flush", 32'(flush_s), 0);
    rd(8'h04, 3'd4, d, e);
    chk("R3 full value stored", d, 32'hABCD_0042);
    wr(8'h04, 32'hABCD_0042, 3'd4, e);
    chk("R3 identical no flush", 32'(flush_s), 0);
  endtask

  task automatic t_masks();
    logic [31:0] d; logic e;
    wr(8'h20, 32'hFFFF_FFFF, 3'd4, e);
    rd(8'h20, 3'd4, d, e);
    chk("R4 assist mask", d, 32'h0000_000F);
    for (int a = 'h14; a <= 'h1C; a += 4) begin
      wr(8'(a), 32'hFFFF_FFFF, 3'd4, e);
      rd(8'(a), 3'd4, d, e);
      chk("R5 event mask", d, 32'h0000_07FF);
    end
    for (int a = 'h08; a <= 'h10; a += 4) begin
      wr(8'(a), 32'hDEAD_BEEF ^ 32'(a), 3'd4, e);
      rd(8'(a), 3'd4, d, e);
      chk("R6 full width", d, 32'hDEAD_BEEF ^ 32'(a));
      chk("R6 no err", 32'(e), 0);
    end
  endtask

  task automatic t_refresh();
    logic [31:0] d; logic e;
    rd(8'h24, 3'd4, d, e);
    chk("R7 refresh read 1", d, 1);
    rd(8'h24, 3'd4, d, e);
    chk("R7 refresh read 2", d, 2);
    wr(8'h24, 32'h0000_0010, 3'd4, e);
    rd(8'h24, 3'd4, d, e);
    chk("R7 refresh loaded", d, 32'h10);
    rd(8'h24, 3'd2, d, e);
    chk("R8 bad size read err", 32'(e), 1);
    chk("R8 bad size read data", d, 0);
    rd(8'h24, 3'd4, d, e);
    chk("R7 refresh after bad read", d, 32'h11);
  endtask

  task automatic t_errors();
    logic [31:0] d; logic e;
    wr(8'h08, 32'h1111_2222, 3'd2, e);
    chk("R8 size err", 32'(e), 1);
    rd(8'h08, 3'd4, d, e);
    chk("R8 reg unchanged", d, 32'hDEAD_BEEF ^ 32'h08);
    wr(8'h00, 32'h0000_0004, 3'd1, e);
    chk("R8 no inv on bad size", 32'(inv_s), 0);
    wr(8'h04, 32'h0000_0077, 3'd8, e);
    chk("R8 no flush on bad size", 32'(flush_s), 0);
    rd(8'h28, 3'd4, d, e);
    chk("R9 unmapped err", 32'(e), 1);
    chk("R9 unmapped data", d, 0);
    rd(8'h02, 3'd4, d, e);
    chk("R9 misaligned err", 32'(e), 1);
    rd(8'h30, 3'd4, d, e);
    chk("R10 cpu ver", d, CPUV);
    rd(8'h34, 3'd4, d, e);
    chk("R10 cache ver", d, CACV);
    rd(8'h38, 3'd4, d, e);
    chk("R10 revision", d, REVV);
    chk("R10 read no err", 32'(e), 0);
    wr(8'h30, 32'h0, 3'd4, e);
    chk("R10 write err", 32'(e), 1);
    rd(8'h30, 3'd4, d, e);
    chk("R10 unchanged", d, CPUV);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_invalidate();
    t_flush();
    t_masks();
    t_refresh();
    t_errors();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule